// File: doc/BRIEF.md
# Stall-Hiding Group Interleave Scheduler

This block feeds one shader core's issue stage. Several groups of fragments live on the core at once, and each one owns a context slot. Every cycle the scheduler names one runnable group to issue. When that group starts a long-latency operation, such as a texture fetch that can take hundreds or thousands of cycles, issue marks it stalled and the scheduler turns to another runnable group. The stalled group becomes runnable again when memory returns a completion tag carrying its slot index. A group that finishes gives up its slot.

How many slots can be used is not fixed. It comes from dividing a fixed register pool by the register footprint of one context, given on `ctx_regs_i`. A large footprint allows few resident groups and so hides less latency. A small footprint allows many. The hardware holds at most `MAX_SLOTS` slots, and the footprint setting decides how many of them a launch may claim. Groups change only when one stalls or retires. There is no time slicing.

Top module: `gis_top`

## Requirements
- R1: After reset every slot is free, `idle_o` is 1, `issue_valid_o` is 0, and with a nonzero capacity `launch_ready_o` is 1 and `launch_slot_o` is 0.
- R2: The number of usable slots is `MAX_SLOTS` when `ctx_regs_i` is 0, and otherwise min(`MAX_SLOTS`, floor(`POOL_REGS` / `ctx_regs_i`)). Slots 0 through that count minus one are the usable ones. `launch_ready_o` is 1 exactly when one of the usable slots is free, so a footprint larger than the pool allows no launch.
- R3: `launch_slot_o` is the lowest-index free usable slot. A launch with `launch_valid_i` high while `launch_ready_o` is high takes that slot, and the slot becomes runnable in the next cycle. A launch while `launch_ready_o` is low has no effect.
- R4: Among the runnable slots, `issue_slot_o` is the first one found searching upward and wrapping around from the slot after the last one issued. After reset the search starts at slot 0.
- R5: `stall_i` high in a cycle with `issue_valid_o` high makes the issued slot stalled from the next cycle on. A stalled slot is never issued.
- R6: A completion tag (`wake_valid_i`, `wake_slot_i`) naming a stalled slot makes it runnable in the next cycle. A tag naming a slot in any other state has no effect.
- R7: `retire_i` high in a cycle with `issue_valid_o` high makes the issued slot done for exactly one cycle, during which it is neither issued nor offered to a launch. It is free in the cycle after that.
- R8: When no slot is runnable, `idle_o` is 1 and `issue_valid_o` is 0. Otherwise `idle_o` is 0 and `issue_valid_o` is 1.
- R9: When `retire_i` and `stall_i` are both high for the same issue, the retire takes effect and the slot does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctx_regs_i | input | REGS_W | Registers each context needs; 0 means use every slot |
| launch_valid_i | input | 1 | Request to place a new group |
| launch_ready_o | output | 1 | A free usable slot exists |
| launch_slot_o | output | SLOT_W | Slot a launch in this cycle takes |
| issue_valid_o | output | 1 | A group is issued this cycle |
| issue_slot_o | output | SLOT_W | Slot of the issued group |
| idle_o | output | 1 | No runnable group this cycle |
| stall_i | input | 1 | Issued group starts a long-latency operation |
| retire_i | input | 1 | Issued group finishes |
| wake_valid_i | input | 1 | Completion tag valid |
| wake_slot_i | input | SLOT_W | Slot named by the completion tag |

## Verification
The bench goes after the boundary of the capacity divide at footprints that divide the pool exactly, that leave a remainder, that are zero, and that exceed the pool. A wrong divide would offer a slot outside the pool or hold back one that fits. It stalls and retires groups on the same issue, and sends completion tags to runnable, free and done slots. A design that let retire lose to stall, or that acted on a misdirected tag, would bring a dead group back to life or lose a live one. It also checks the one-cycle done window and the wrap of the round-robin pointer. A scheduler that freed slots early would let a launch overwrite a context still draining. One that restarted its search at slot 0 would starve the high slots.

// File: rtl/gis_pkg.sv
package gis_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_RUN   = 2'd1,
    SLOT_STALL = 2'd2,
    SLOT_DONE  = 2'd3
  } slot_state_e;
endpackage

// File: rtl/gis_slot_table.sv
module gis_slot_table
  import gis_pkg::*;
#(
  parameter int N  = 32,
  parameter int SW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_valid_i,
  input  logic [SW-1:0] issue_slot_i,
  input  logic          stall_i,
  input  logic          retire_i,
  input  logic          wake_valid_i,
  input  logic [SW-1:0] wake_slot_i,
  input  logic          launch_fire_i,
  input  logic [SW-1:0] launch_slot_i,
  output logic [N-1:0]  run_o,
  output logic [N-1:0]  free_o
);

  for (genvar k = 0; k < N; k++) begin : g_slot
    slot_state_e st_q;
    logic        hit_issue, hit_wake, hit_launch;

    assign hit_issue  = issue_valid_i && (issue_slot_i == SW'(k));
    assign hit_wake   = wake_valid_i && (wake_slot_i == SW'(k));
    assign hit_launch = launch_fire_i && (launch_slot_i == SW'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q <= SLOT_FREE;
      end else begin
        unique case (st_q)
          SLOT_FREE:  if (hit_launch) st_q <= SLOT_RUN;
          SLOT_RUN: begin
            // retire outranks stall
            if (hit_issue && retire_i)     st_q <= SLOT_DONE;
            else if (hit_issue && stall_i) st_q <= SLOT_STALL;
          end
          SLOT_STALL: if (hit_wake) st_q <= SLOT_RUN;
          SLOT_DONE:  st_q <= SLOT_FREE;
          default:    st_q <= SLOT_FREE;
        endcase
      end
    end

    assign run_o[k]  = (st_q == SLOT_RUN);
    assign free_o[k] = (st_q == SLOT_FREE);

    // R6
    wake_revive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_wake && !run_o[k] && !free_o[k] && !$past(hit_issue && retire_i && run_o[k]))
        |=> (run_o[k] || !$past(st_q == SLOT_STALL)));
  end

endmodule

// File: rtl/gis_rr_pick.sv
module gis_rr_pick #(
  parameter int N  = 32,
  parameter int SW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [SW-1:0] slot_o
);

  logic [SW-1:0] last_q;

  always_comb begin
    int idx;
    valid_o = 1'b0;
    slot_o  = '0;
    for (int off = 1; off <= N; off++) begin
      idx = int'(last_q) + off;
      if (idx >= N) idx = idx - N;
      if (!valid_o && req_i[idx]) begin
        valid_o = 1'b1;
        slot_o  = SW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_q <= SW'(N-1);
    else if (valid_o) last_q <= slot_o;
  end

  // R4
  pick_runnable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> req_i[slot_o]);

  // R4
  rr_rotate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && $past(req_i) == req_i && $countones(req_i) > 1)
      |-> slot_o != $past(slot_o));

endmodule

// File: rtl/gis_free_pick.sv
module gis_free_pick #(
  parameter int N         = 32,
  parameter int SW        = 5,
  parameter int RW        = 14,
  parameter int POOL_REGS = 8192
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ctx_regs_i,
  input  logic [N-1:0]  free_i,
  output logic          ready_o,
  output logic [SW-1:0] slot_o
);

  localparam int PW = RW + SW + 2;

  logic [N-1:0] usable, avail;

  for (genvar k = 0; k < N; k++) begin : g_fit
    // slot k fits when (k+1) contexts fit in the pool
    assign usable[k] = (ctx_regs_i == '0) ||
                       ((PW'(k + 1) * PW'(ctx_regs_i)) <= PW'(POOL_REGS));
  end

  assign avail   = free_i & usable;
  assign ready_o = |avail;

  always_comb begin
    slot_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (avail[k]) slot_o = SW'(k);
    end
  end

  // R3
  pick_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> free_i[slot_o]);

endmodule

// File: rtl/gis_top.sv
module gis_top #(
  parameter int MAX_SLOTS = 32,
  parameter int POOL_REGS = 8192,
  parameter int REGS_W    = 14,
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REGS_W-1:0] ctx_regs_i,
  input  logic              launch_valid_i,
  output logic              launch_ready_o,
  output logic [SLOT_W-1:0] launch_slot_o,
  output logic              issue_valid_o,
  output logic [SLOT_W-1:0] issue_slot_o,
  output logic              idle_o,
  input  logic              stall_i,
  input  logic              retire_i,
  input  logic              wake_valid_i,
  input  logic [SLOT_W-1:0] wake_slot_i
);

  logic [MAX_SLOTS-1:0] run_vec, free_vec;
  logic                 launch_fire;

  assign launch_fire = launch_valid_i && launch_ready_o;

  gis_slot_table #(.N(MAX_SLOTS), .SW(SLOT_W)) i_table (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .issue_valid_i (issue_valid_o),
    .issue_slot_i  (issue_slot_o),
    .stall_i       (stall_i),
    .retire_i      (retire_i),
    .wake_valid_i  (wake_valid_i),
    .wake_slot_i   (wake_slot_i),
    .launch_fire_i (launch_fire),
    .launch_slot_i (launch_slot_o),
    .run_o         (run_vec),
    .free_o        (free_vec)
  );

  gis_rr_pick #(.N(MAX_SLOTS), .SW(SLOT_W)) i_rr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (run_vec),
    .valid_o (issue_valid_o),
    .slot_o  (issue_slot_o)
  );

  gis_free_pick #(
    .N(MAX_SLOTS), .SW(SLOT_W), .RW(REGS_W), .POOL_REGS(POOL_REGS)
  ) i_free (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctx_regs_i (ctx_regs_i),
    .free_i     (free_vec),
    .ready_o    (launch_ready_o),
    .slot_o     (launch_slot_o)
  );

  assign idle_o = !issue_valid_o;

  // R5
  stall_no_reissue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && stall_i) |=> !(issue_valid_o && issue_slot_o == $past(issue_slot_o)));

  // R7
  retire_no_reissue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && retire_i) |=> !(issue_valid_o && issue_slot_o == $past(issue_slot_o)));

  // R7
  retire_hold_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && retire_i) |=> !(launch_ready_o && launch_slot_o == $past(issue_slot_o)));

  // R3
  launch_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_fire |=> !(launch_ready_o && launch_slot_o == $past(launch_slot_o)));

endmodule

// File: tb/test_gis_top.sv
`timescale 1ns/1ps
module test_gis_top;
  localparam int NS   = 32;
  localparam int POOL = 8192;
  localparam int RW   = 14;
  localparam int SW   = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] ctx_regs = '0;
  logic          lv = 1'b0, st = 1'b0, rt = 1'b0, wv = 1'b0;
  logic [SW-1:0] ws = '0;
  logic          l_rdy, i_vld, idle;
  logic [SW-1:0] l_slot, i_slot;

  int n_chk = 0, n_fail = 0;
  int m_st [NS];   // 0 free 1 run 2 stall 3 done
  int m_last = NS - 1;

  always #4 clk = ~clk;

  gis_top #(.MAX_SLOTS(NS), .POOL_REGS(POOL), .REGS_W(RW)) i_gis_top (
    .clk_i(clk), .rst_ni(rst_n), .ctx_regs_i(ctx_regs),
    .launch_valid_i(lv), .launch_ready_o(l_rdy), .launch_slot_o(l_slot),
    .issue_valid_o(i_vld), .issue_slot_o(i_slot), .idle_o(idle),
    .stall_i(st), .retire_i(rt), .wake_valid_i(wv), .wake_slot_i(ws)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int m_cap();
    int c;
    if (ctx_regs == 0) return NS;
    c = POOL / int'(ctx_regs);
    return (c > NS) ? NS : c;
  endfunction

  function automatic int m_free();
    for (int k = 0; k < m_cap(); k++) if (m_st[k] == 0) return k;
    return -1;
  endfunction

  function automatic int m_pick();
    for (int off = 1; off <= NS; off++) begin
      int idx = (m_last + off) % NS;
      if (m_st[idx] == 1) return idx;
    end
    return -1;
  endfunction

  function automatic int m_first(input int state);
    for (int k = 0; k < NS; k++) if (m_st[k] == state) return k;
    return -1;
  endfunction

  // one clock: drive, compare against model, advance model
  task automatic cyc(input bit a_lv, input bit a_st, input bit a_rt, input bit a_wv, input int a_ws);
    int p, f;
    int nx [NS];
    lv = a_lv; st = a_st; rt = a_rt; wv = a_wv; ws = SW'(a_ws);
    #1;
    p = m_pick();
    f = m_free();
    chk(idle == (p < 0), "R8", "idle_o", int'(idle), int'(p < 0));
    chk(i_vld == (p >= 0), "R8", "issue_valid_o", int'(i_vld), int'(p >= 0));
    if (p >= 0) chk(int'(i_slot) == p, "R4", "issue_slot_o", int'(i_slot), p);
    chk(l_rdy == (f >= 0), "R2", "launch_ready_o", int'(l_rdy), int'(f >= 0));
    if (f >= 0) chk(int'(l_slot) == f, "R3", "launch_slot_o", int'(l_slot), f);
    for (int k = 0; k < NS; k++) nx[k] = (m_st[k] == 3) ? 0 : m_st[k];
    if (p >= 0) begin
      if (a_rt) nx[p] = 3;
      else if (a_st) nx[p] = 2;
      m_last = p;
    end
    if (a_wv && m_st[a_ws] == 2) nx[a_ws] = 1;
    if (a_lv && f >= 0) nx[f] = 1;
    for (int k = 0; k < NS; k++) m_st[k] = nx[k];
    @(negedge clk);
    lv = 1'b0; st = 1'b0; rt = 1'b0; wv = 1'b0;
    #1;
  endtask

  task automatic idle_cyc();
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic run_until(input int slot);
    for (int i = 0; i < 3 * NS && m_pick() != slot; i++) idle_cyc();
  endtask

  task automatic drain();
    for (int i = 0; i < 8 * NS; i++) begin
      int w = m_first(2);
      if (m_first(1) < 0 && w < 0 && m_first(3) < 0) break;
      cyc(1'b0, 1'b0, 1'b1, w >= 0, (w >= 0) ? w : 0);
    end
  endtask

  task automatic fill_count(output int n);
    n = 0;
    for (int i = 0; i < NS + 2; i++) begin
      if (m_free() >= 0) n++;
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 0);
    end
  endtask

  initial begin
    int n;
    bit seen;
    for (int k = 0; k < NS; k++) m_st[k] = 0;
    ctx_regs = RW'(2048);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(idle == 1'b1, "R1", "idle_o after reset", int'(idle), 1);
    chk(i_vld == 1'b0, "R1", "issue_valid_o after reset", int'(i_vld), 0);
    chk(l_rdy == 1'b1, "R1", "launch_ready_o after reset", int'(l_rdy), 1);
    chk(l_slot == '0, "R1", "launch_slot_o after reset", int'(l_slot), 0);

    // R2 footprint 2048 gives four slots
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 0);
    chk(l_rdy == 1'b0, "R2", "ready with 4 of 4 slots used", int'(l_rdy), 0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 0);   // R3 rejected launch
    for (int i = 0; i < 6; i++) idle_cyc();

    // R5 stall slot 1
    run_until(1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 0);
    for (int i = 0; i < 8; i++) begin
      chk(!(i_vld && i_slot == 5'd1), "R5", "stalled slot issued", int'(i_slot), -1);
      idle_cyc();
    end
    // R6 misdirected tags: runnable slot 0, free slot 9
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 9);
    chk(l_rdy == 1'b0, "R6", "tag to free slot changed capacity", int'(l_rdy), 0);
    // R6 wake slot 1
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1);
    seen = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (i_vld && i_slot == 5'd1) seen = 1'b1;
      idle_cyc();
    end
    chk(seen, "R6", "woken slot 1 issued", int'(seen), 1);

    // R7 retire slot 2: done one cycle, then free
    run_until(2);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 0);
    chk(l_rdy == 1'b0, "R7", "ready during done cycle", int'(l_rdy), 0);
    idle_cyc();
    chk(l_rdy == 1'b1, "R7", "ready after done cycle", int'(l_rdy), 1);
    chk(l_slot == 5'd2, "R7", "freed slot offered", int'(l_slot), 2);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 0);

    // R9 stall and retire together on slot 3, tag sent while done
    run_until(3);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 3);
    chk(l_rdy == 1'b1, "R9", "retire beat stall, slot freed", int'(l_rdy), 1);
    chk(l_slot == 5'd3, "R9", "slot 3 free", int'(l_slot), 3);

    // R8 stall every runnable group
    for (int i = 0; i < NS && m_pick() >= 0; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 0);
    chk(idle == 1'b1, "R8", "idle with all stalled", int'(idle), 1);
    chk(i_vld == 1'b0, "R8", "no issue with all stalled", int'(i_vld), 0);
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 1'b0, 1'b1, k);
    idle_cyc();
    chk(idle == 1'b0, "R8", "busy after wakes", int'(idle), 0);

    // R2 capacity at other footprints
    drain();
    ctx_regs = RW'(384);   // 8192/384 = 21
    fill_count(n);
    chk(n == 21, "R2", "launches at footprint 384", n, 21);
    drain();
    ctx_regs = '0;
    fill_count(n);
    chk(n == NS, "R2", "launches at footprint 0", n, NS);
    drain();
    ctx_regs = RW'(9000);
    #1;
    chk(l_rdy == 1'b0, "R2", "footprint over pool", int'(l_rdy), 0);
    ctx_regs = RW'(8192);
    #1;
    chk(l_rdy == 1'b1 && l_slot == '0, "R2", "footprint equal to pool", int'(l_rdy), 1);
    fill_count(n);
    chk(n == 1, "R2", "launches at footprint 8192", n, 1);
    drain();

    // mixed traffic, R4 wrap and everything else through the model
    ctx_regs = RW'(1024);
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      cyc(r < 50, (r % 5) == 0, (r % 10) == 3, int'($urandom_range(0, 9)) < 4,
          int'($urandom_range(0, NS - 1)));
    end
    drain();
    ctx_regs = RW'(256);
    for (int i = 0; i < 2000; i++) begin
      int r = int'($urandom_range(0, 99));
      cyc(r < 30, (r % 3) == 0, (r % 17) == 1, int'($urandom_range(0, 9)) < 6,
          int'($urandom_range(0, NS - 1)));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule